// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block sits between instruction fetch and execute in a small 16-bit processor. From an opcode word, the address that word was fetched from, the two words that follow it in the instruction stream, and the current register file contents, it works out where each operand lives. The source operand comes out as a register, a memory location with its effective address, or a ready-made value (a generated constant or an immediate). The destination comes out as a register, a memory location, or absent for single-operand instructions.

Along with the operands, the block reports four things. It gives the number of extension words the instruction consumes and the resulting next program counter. It raises any register post-increment request, with the register's new value. It also flags when a byte-wide write to a register destination must clear that register's upper byte. All results are registered and appear one clock after the request.

Two registers double as value sources. One produces four constants, and the other gives two more constants plus absolute addressing. These six common constants therefore cost no extension word.

Top module: `opd_mode_decoder`

## Requirements
- R1: After reset every output is zero. Each request with `dec_valid` high produces results with `op_valid` high exactly one clock later, and `op_valid` is low one clock after a cycle without a request.
- R2: The instruction is single-operand when bits 15:10 equal 6'b000100. In that case the operand register is bits 3:0, `dst_kind` is 3 (none) and `dst_reg` is 0. Otherwise the source register is bits 11:8 and the destination register is bits 3:0. `is_byte` reports bit 6 and `is_single` the format. Source mode is bits 5:4, and `src_kind` is encoded 0 register, 1 memory, 2 value.
- R3: Source register 3 gives value kind with 0, 1, 2, 16'hFFFF for modes 0..3, and consumes no extension word.
- R4: Source register 2 behaves by mode as follows. Mode 0 is register 2. Mode 1 is memory at address = the extension word (one word consumed). Mode 2 is value 4 and mode 3 is value 8, both with no extension word.
- R5: Source register 0 behaves by mode as follows. Mode 0 is register 0. Mode 1 is memory at (instr_addr+2) + extension word. Mode 2 is memory at instr_addr+2. Mode 3 is a value equal to the extension word. Modes 1 and 3 consume one word.
- R6: Any other source register n behaves by mode as follows. Mode 0 is register n. Mode 1 is memory at rf[n] + extension word, consuming one word. Mode 2 is memory at rf[n].
- R7: Any other source register n in mode 3 is memory at rf[n] and requests a post-increment of register n to rf[n]+1 when bit 6 is 1, or rf[n]+2 when it is 0 (modulo 2^16). No other case raises `inc_req`.
- R8: For a two-operand instruction, bit 7 = 0 gives a register destination (kind 0). Bit 7 = 1 gives a memory destination (kind 1) using one extension word. For register 2 the address is that word itself. For register 0 it is the word's own address plus the word. For any other register n it is rf[n] plus the word.
- R9: The source's extension word, if any, comes first at instr_addr+2. The destination's word is then `ext_word1` at instr_addr+4; otherwise it is `ext_word0` at instr_addr+2.
- R10: `ext_used` counts the consumed extension words (0 to 2), and `pc_next` = instr_addr + 2 + 2*ext_used.
- R11: `clr_upper` is 1 exactly for two-operand instructions with bit 7 = 0 and bit 6 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode request this cycle |
| instr | input | 16 | Opcode word |
| instr_addr | input | 16 | Address the opcode was fetched from |
| ext_word0 | input | 16 | Word at instr_addr+2 |
| ext_word1 | input | 16 | Word at instr_addr+4 |
| rf_flat | input | 256 | Register file, register n at bits 16n+15:16n |
| op_valid | output | 1 | Results valid |
| is_single | output | 1 | Single-operand format |
| is_byte | output | 1 | Byte-wide operation |
| src_kind | output | 2 | 0 register, 1 memory, 2 value |
| src_reg | output | 4 | Source register index |
| src_addr | output | 16 | Source effective address (0 unless memory) |
| src_value | output | 16 | Constant or immediate (0 unless value) |
| dst_kind | output | 2 | 0 register, 1 memory, 3 none |
| dst_reg | output | 4 | Destination register index |
| dst_addr | output | 16 | Destination effective address (0 unless memory) |
| ext_used | output | 2 | Extension words consumed |
| pc_next | output | 16 | Program counter after the instruction stream |
| inc_req | output | 1 | Post-increment request |
| inc_reg | output | 4 | Register to increment |
| inc_value | output | 16 | New value for that register |
| clr_upper | output | 1 | Clear upper byte of destination register |

## Verification
On every result cycle, the assertions check several relations between outputs. They cover the one-clock latency, the program-counter advance against the word count, the agreement of the post-increment value with the source address and width, the upper-byte clear being tied to byte register destinations, and the absence of a destination and a word cost for constant-generator single-operand forms. Only the bench's sweep can show that each register and mode combination picks the right address base and the right extension word. It also covers the source-before-destination word ordering and the exact constant values.

// File: rtl/opd_pkg.sv
package opd_pkg;

    localparam int unsigned OPD_W   = 16;
    localparam int unsigned NREG    = 16;
    localparam int unsigned REG_AW  = $clog2(NREG);
    localparam int unsigned RF_W    = NREG * OPD_W;

    localparam logic [REG_AW-1:0] R_PC = REG_AW'(0);
    localparam logic [REG_AW-1:0] R_SR = REG_AW'(2);
    localparam logic [REG_AW-1:0] R_CG = REG_AW'(3);

    localparam logic [5:0] SINGLE_TAG = 6'b000100;

    typedef enum logic [1:0] {
        SK_REG = 2'd0,
        SK_MEM = 2'd1,
        SK_VAL = 2'd2
    } src_kind_e;

    typedef enum logic [1:0] {
        DK_REG  = 2'd0,
        DK_MEM  = 2'd1,
        DK_NONE = 2'd3
    } dst_kind_e;

    typedef struct packed {
        src_kind_e          kind;
        logic [REG_AW-1:0]  ridx;
        logic [OPD_W-1:0]   addr;
        logic [OPD_W-1:0]   value;
        logic               ext;
        logic               inc;
        logic [OPD_W-1:0]   inc_value;
    } src_dec_t;

    typedef struct packed {
        dst_kind_e          kind;
        logic [REG_AW-1:0]  ridx;
        logic [OPD_W-1:0]   addr;
        logic               ext;
        logic               clr;
    } dst_dec_t;

    function automatic logic is_single_fmt(input logic [15:0] op);
        return op[15:10] == SINGLE_TAG;
    endfunction

    // Value produced by the generator registers; zero for anything else.
    function automatic logic [OPD_W-1:0] gen_const(input logic [REG_AW-1:0] r,
                                                   input logic [1:0] m);
        logic [OPD_W-1:0] v;
        v = '0;
        if (r == R_CG) begin
            case (m)
                2'd0: v = OPD_W'(0);
                2'd1: v = OPD_W'(1);
                2'd2: v = OPD_W'(2);
                default: v = '1;
            endcase
        end else if (r == R_SR) begin
            if (m == 2'd2) v = OPD_W'(4);
            else if (m == 2'd3) v = OPD_W'(8);
        end
        return v;
    endfunction

endpackage

// File: rtl/opd_rf_read.sv
module opd_rf_read
    import opd_pkg::*;
(
    input  logic [RF_W-1:0]   rf_flat,
    input  logic [REG_AW-1:0] idx,
    output logic [OPD_W-1:0]  val
);
    logic [OPD_W-1:0] words [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign words[g] = rf_flat[g*OPD_W +: OPD_W];
    end

    assign val = words[idx];
endmodule

// File: rtl/opd_src_dec.sv
module opd_src_dec
    import opd_pkg::*;
(
    input  logic [REG_AW-1:0] sreg,
    input  logic [1:0]        mode,
    input  logic              byte_op,
    input  logic [OPD_W-1:0]  cursor,
    input  logic [OPD_W-1:0]  ext,
    input  logic [OPD_W-1:0]  rval,
    output src_dec_t          dec
);
    always_comb begin
        dec      = '0;
        dec.ridx = sreg;
        if (sreg == R_CG) begin
            dec.kind  = SK_VAL;
            dec.value = gen_const(sreg, mode);
        end else if (sreg == R_SR) begin
            case (mode)
                2'd0: dec.kind = SK_REG;
                2'd1: begin
                    dec.kind = SK_MEM;
                    dec.addr = ext;
                    dec.ext  = 1'b1;
                end
                default: begin
                    dec.kind  = SK_VAL;
                    dec.value = gen_const(sreg, mode);
                end
            endcase
        end else if (sreg == R_PC) begin
            case (mode)
                2'd0: dec.kind = SK_REG;
                2'd1: begin
                    dec.kind = SK_MEM;
                    dec.addr = cursor + ext;
                    dec.ext  = 1'b1;
                end
                2'd2: begin
                    dec.kind = SK_MEM;
                    dec.addr = cursor;
                end
                default: begin
                    dec.kind  = SK_VAL;
                    dec.value = ext;
                    dec.ext   = 1'b1;
                end
            endcase
        end else begin
            case (mode)
                2'd0: dec.kind = SK_REG;
                2'd1: begin
                    dec.kind = SK_MEM;
                    dec.addr = rval + ext;
                    dec.ext  = 1'b1;
                end
                2'd2: begin
                    dec.kind = SK_MEM;
                    dec.addr = rval;
                end
                default: begin
                    dec.kind      = SK_MEM;
                    dec.addr      = rval;
                    dec.inc       = 1'b1;
                    dec.inc_value = rval + (byte_op ? OPD_W'(1) : OPD_W'(2));
                end
            endcase
        end
    end
endmodule

// File: rtl/opd_dst_dec.sv
module opd_dst_dec
    import opd_pkg::*;
(
    input  logic              single,
    input  logic              dmode,
    input  logic              byte_op,
    input  logic [REG_AW-1:0] dreg,
    input  logic [OPD_W-1:0]  cursor,
    input  logic [OPD_W-1:0]  ext,
    input  logic [OPD_W-1:0]  rval,
    output dst_dec_t          dec
);
    always_comb begin
        dec = '0;
        if (single) begin
            dec.kind = DK_NONE;
        end else if (!dmode) begin
            dec.kind = DK_REG;
            dec.ridx = dreg;
            dec.clr  = byte_op;
        end else begin
            dec.kind = DK_MEM;
            dec.ridx = dreg;
            dec.ext  = 1'b1;
            if (dreg == R_SR)      dec.addr = ext;
            else if (dreg == R_PC) dec.addr = cursor + ext;
            else                   dec.addr = rval + ext;
        end
    end
endmodule

// File: rtl/opd_mode_decoder.sv
module opd_mode_decoder
    import opd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                dec_valid,
    input  logic [15:0]         instr,
    input  logic [OPD_W-1:0]    instr_addr,
    input  logic [OPD_W-1:0]    ext_word0,
    input  logic [OPD_W-1:0]    ext_word1,
    input  logic [RF_W-1:0]     rf_flat,
    output logic                op_valid,
    output logic                is_single,
    output logic                is_byte,
    output logic [1:0]          src_kind,
    output logic [REG_AW-1:0]   src_reg,
    output logic [OPD_W-1:0]    src_addr,
    output logic [OPD_W-1:0]    src_value,
    output logic [1:0]          dst_kind,
    output logic [REG_AW-1:0]   dst_reg,
    output logic [OPD_W-1:0]    dst_addr,
    output logic [1:0]          ext_used,
    output logic [OPD_W-1:0]    pc_next,
    output logic                inc_req,
    output logic [REG_AW-1:0]   inc_reg,
    output logic [OPD_W-1:0]    inc_value,
    output logic                clr_upper
);
    logic              single_c, byte_c;
    logic [REG_AW-1:0] sreg_c, dreg_c;
    logic [OPD_W-1:0]  s_rval, d_rval;
    logic [OPD_W-1:0]  src_cursor, dst_cursor, dst_ext;
    logic [1:0]        ext_c;
    src_dec_t          src_c, src_q;
    dst_dec_t          dst_c, dst_q;
    logic              valid_q, single_q, byte_q;
    logic [1:0]        ext_q;
    logic [OPD_W-1:0]  pc_q;

    assign single_c   = is_single_fmt(instr);
    assign byte_c     = instr[6];
    assign dreg_c     = instr[3:0];
    assign sreg_c     = single_c ? instr[3:0] : instr[11:8];
    assign src_cursor = instr_addr + OPD_W'(2);

    opd_rf_read u_src_rd (.rf_flat(rf_flat), .idx(sreg_c), .val(s_rval));
    opd_rf_read u_dst_rd (.rf_flat(rf_flat), .idx(dreg_c), .val(d_rval));

    opd_src_dec u_src (
        .sreg(sreg_c), .mode(instr[5:4]), .byte_op(byte_c),
        .cursor(src_cursor), .ext(ext_word0), .rval(s_rval), .dec(src_c)
    );

    // Destination word follows the source word when the source used one.
    assign dst_ext    = src_c.ext ? ext_word1 : ext_word0;
    assign dst_cursor = src_c.ext ? instr_addr + OPD_W'(4) : src_cursor;

    opd_dst_dec u_dst (
        .single(single_c), .dmode(instr[7]), .byte_op(byte_c), .dreg(dreg_c),
        .cursor(dst_cursor), .ext(dst_ext), .rval(d_rval), .dec(dst_c)
    );

    assign ext_c = {1'b0, src_c.ext} + {1'b0, dst_c.ext};

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            single_q <= 1'b0;
            byte_q   <= 1'b0;
            ext_q    <= '0;
            pc_q     <= '0;
            src_q    <= '0;
            dst_q    <= '0;
        end else begin
            valid_q <= dec_valid;
            if (dec_valid) begin
                single_q <= single_c;
                byte_q   <= byte_c;
                ext_q    <= ext_c;
                pc_q     <= src_cursor + {{(OPD_W-3){1'b0}}, ext_c, 1'b0};
                src_q    <= src_c;
                dst_q    <= dst_c;
            end
        end
    end

    assign op_valid  = valid_q;
    assign is_single = single_q;
    assign is_byte   = byte_q;
    assign src_kind  = src_q.kind;
    assign src_reg   = src_q.ridx;
    assign src_addr  = src_q.addr;
    assign src_value = src_q.value;
    assign dst_kind  = dst_q.kind;
    assign dst_reg   = dst_q.ridx;
    assign dst_addr  = dst_q.addr;
    assign ext_used  = ext_q;
    assign pc_next   = pc_q;
    assign inc_req   = src_q.inc;
    assign inc_reg   = src_q.inc ? src_q.ridx : '0;
    assign inc_value = src_q.inc_value;
    assign clr_upper = dst_q.clr;
endmodule

// File: rtl/opd_mode_decoder_chk.sv
module opd_mode_decoder_chk
    import opd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              dec_valid,
    input logic [OPD_W-1:0]  instr_addr,
    input logic              op_valid,
    input logic              is_single,
    input logic              is_byte,
    input logic [1:0]        src_kind,
    input logic [REG_AW-1:0] src_reg,
    input logic [OPD_W-1:0]  src_addr,
    input logic [1:0]        dst_kind,
    input logic [1:0]        ext_used,
    input logic [OPD_W-1:0]  pc_next,
    input logic              inc_req,
    input logic [REG_AW-1:0] inc_reg,
    input logic [OPD_W-1:0]  inc_value,
    input logic              clr_upper
);
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (op_valid == $past(dec_valid)));

    p_single_nodst_r2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_single) |-> (dst_kind == 2'd3 && !clr_upper));

    p_cgen_free_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_single && src_reg == REG_AW'(3)) |->
            (src_kind == 2'd2 && ext_used == 2'd0));

    p_autoinc_step_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && inc_req) |->
            (src_kind == 2'd1 && inc_reg == src_reg &&
             inc_value == src_addr + (is_byte ? OPD_W'(1) : OPD_W'(2))));

    p_pc_advance_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !$past(rst)) |->
            (ext_used <= 2'd2 &&
             pc_next == $past(instr_addr) + OPD_W'(2) + OPD_W'({ext_used, 1'b0})));

    p_clear_upper_r11: assert property (@(posedge clk) disable iff (rst)
        (op_valid && clr_upper) |-> (dst_kind == 2'd0 && is_byte && !is_single));
endmodule

bind opd_mode_decoder opd_mode_decoder_chk u_chk (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .instr_addr(instr_addr),
    .op_valid(op_valid), .is_single(is_single), .is_byte(is_byte),
    .src_kind(src_kind), .src_reg(src_reg), .src_addr(src_addr),
    .dst_kind(dst_kind), .ext_used(ext_used), .pc_next(pc_next),
    .inc_req(inc_req), .inc_reg(inc_reg), .inc_value(inc_value),
    .clr_upper(clr_upper)
);

// File: tb/opd_mode_decoder_bench.sv
`timescale 1ns/1ps
module opd_mode_decoder_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         dec_valid;
    logic [15:0]  instr, instr_addr, ext_word0, ext_word1;
    logic [255:0] rf_flat;
    logic         op_valid, is_single, is_byte, inc_req, clr_upper;
    logic [1:0]   src_kind, dst_kind, ext_used;
    logic [3:0]   src_reg, dst_reg, inc_reg;
    logic [15:0]  src_addr, src_value, dst_addr, pc_next, inc_value;

    int total = 0;
    int bad   = 0;

    logic [15:0] rf [16];

    always #2 clk = ~clk;

    opd_mode_decoder u_opd_mode_decoder (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .instr(instr),
        .instr_addr(instr_addr), .ext_word0(ext_word0), .ext_word1(ext_word1),
        .rf_flat(rf_flat), .op_valid(op_valid), .is_single(is_single),
        .is_byte(is_byte), .src_kind(src_kind), .src_reg(src_reg),
        .src_addr(src_addr), .src_value(src_value), .dst_kind(dst_kind),
        .dst_reg(dst_reg), .dst_addr(dst_addr), .ext_used(ext_used),
        .pc_next(pc_next), .inc_req(inc_req), .inc_reg(inc_reg),
        .inc_value(inc_value), .clr_upper(clr_upper)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s instr=%h act=%h exp=%h", tag, instr, act, exp);
        end
    endtask

    task automatic run_one(input bit single, input int sr, input int md, input bit bw,
                           input bit ad, input int dr, input int n);
        logic [3:0]  s;
        logic [1:0]  ek, sk, dk;
        logic [15:0] sa, sv, da, iv, base, dext;
        logic        se, de, inc;
        string       stag, dtag;
        s = single ? 4'(dr) : 4'(sr);
        instr      = single ? {6'b000100, 2'b00, ad, bw, 2'(md), 4'(dr)}
                            : {4'h4, 4'(sr), ad, bw, 2'(md), 4'(dr)};
        instr_addr = 16'h8000 + 16'(n * 6);
        ext_word0  = 16'h2000 + 16'(n * 7);
        ext_word1  = 16'h5A00 ^ 16'(n * 13);
        base = instr_addr + 16'd2;
        sk = 2'd0; sa = 0; sv = 0; se = 0; inc = 0; iv = 0;
        if (s == 3) begin
            sk = 2; stag = "R3";
            sv = (md == 3) ? 16'hFFFF : 16'(md);
        end else if (s == 2) begin
            stag = "R4";
            if (md == 1) begin sk = 1; sa = ext_word0; se = 1; end
            else if (md >= 2) begin sk = 2; sv = (md == 2) ? 16'd4 : 16'd8; end
        end else if (s == 0) begin
            stag = "R5";
            if (md == 1) begin sk = 1; sa = base + ext_word0; se = 1; end
            else if (md == 2) begin sk = 1; sa = base; end
            else if (md == 3) begin sk = 2; sv = ext_word0; se = 1; end
        end else begin
            stag = (md == 3) ? "R7" : "R6";
            if (md == 1) begin sk = 1; sa = rf[s] + ext_word0; se = 1; end
            else if (md == 2) begin sk = 1; sa = rf[s]; end
            else if (md == 3) begin
                sk = 1; sa = rf[s]; inc = 1; iv = rf[s] + (bw ? 16'd1 : 16'd2);
            end
        end
        dext = se ? ext_word1 : ext_word0;
        de = 0; da = 0;
        dtag = (ad && se) ? "R9" : "R8";
        if (single) dk = 3;
        else if (!ad) dk = 0;
        else begin
            dk = 1; de = 1;
            if (dr == 2) da = dext;
            else if (dr == 0) da = (se ? instr_addr + 16'd4 : base) + dext;
            else da = rf[dr] + dext;
        end
        ek = 2'(se) + 2'(de);
        dec_valid = 1'b1;
        @(negedge clk);
        dec_valid = 1'b0;
        check("R2", {is_single, is_byte, op_valid}, {single, bw, 1'b1});
        check(stag, {src_kind, src_reg, src_addr, src_value}, {sk, s, sa, sv});
        check(dtag, {dst_kind, dst_reg, dst_addr}, {dk, single ? 4'd0 : 4'(dr), da});
        check("R7", {inc_req, inc_reg, inc_value}, {inc, inc ? s : 4'd0, iv});
        check("R10", {ext_used, pc_next}, {ek, base + 16'(ek * 2)});
        check("R11", {63'd0, clr_upper}, {63'd0, !single && !ad && bw});
    endtask

    initial begin : watchdog
        #800000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        int n;
        for (int i = 0; i < 16; i++) rf[i] = 16'h1111 * 16'(i) ^ 16'h0A5C;
        rf[15] = 16'hFFFF;  // post-increment wraps past the top
        for (int i = 0; i < 16; i++) rf_flat[i*16 +: 16] = rf[i];
        rst = 1'b1; dec_valid = 1'b0;
        instr = 0; instr_addr = 0; ext_word0 = 0; ext_word1 = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {op_valid, is_single, is_byte, src_kind, dst_kind, ext_used, inc_req, clr_upper},
              '0);
        check("R1", {src_addr, src_value, dst_addr, pc_next}, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {63'd0, op_valid}, 64'd0);
        n = 0;
        for (int sg = 0; sg < 2; sg++)
            for (int sr = 0; sr < 16; sr++) begin
                if (sg == 1 && sr != 0) continue;
                for (int md = 0; md < 4; md++)
                    for (int bw = 0; bw < 2; bw++)
                        for (int ad = 0; ad < 2; ad++)
                            for (int dr = 0; dr < 16; dr++) begin
                                @(negedge clk);
                                run_one(sg[0], sr, md, bw[0], ad[0], dr, n);
                                n++;
                            end
            end
        @(negedge clk);
        check("R1", {63'd0, op_valid}, 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule